// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block lets a design running on a single clock read and write an external asynchronous static RAM of 8192 bytes. On the memory side it drives a 13-bit address, a low-true and a high-true chip select, a low-true write strobe and a low-true output enable, and it shares an 8-bit bidirectional data bus with the memory. On the user side a request is offered with an address, a write flag and write data, and it is taken in any cycle where `ready` is high. Each read returns its byte on `rdata` together with a one-cycle `rvalid` pulse.

Every phase length is a whole number of clock cycles. It is found by dividing a nanosecond timing parameter by the clock-period parameter and rounding up, with a floor of one cycle. The controller keeps the address constant for as long as the memory is selected. It keeps the output enable high for the whole of a write. It switches its own data drivers on only after the write strobe has fallen, and it switches them off one cycle after the strobe rises. After a read it waits for the memory's output-disable time before it can start the next access.

Top module: `sram_seq_ctrl`

## Requirements
- R1: During and after reset, with no request taken: `mem_ce_n`=1, `mem_ce2`=0, `mem_we_n`=1, `mem_oe_n`=1, `mem_dq` is not driven, `ready`=1 and `rvalid`=0.
- R2: A request is taken only on a clock edge where `req` and `ready` are both high. `ready` stays low until the access has finished: RD+TA+1 cycles after acceptance for a read and WR+2 cycles for a write (RD, TA and WR are defined below).
- R3: A read selects the memory (`mem_ce_n`=0 and `mem_ce2`=1 together) with `mem_oe_n`=0 and `mem_we_n`=1 for exactly RD = max(ceil(tRC/clk), ceil(tAA/clk), ceil(tACE/clk), 1) cycles. The default is 6.
- R4: Read data is sampled from the bus on the last selected cycle. `rvalid` is high for exactly one cycle, RD+1 cycles after acceptance, and in that cycle `rdata` holds the byte stored at the address.
- R5: After a read the memory is deselected with `mem_oe_n`=1 for TA = ceil(tOHZ/clk) cycles (default 2) before `ready` returns.
- R6: A write holds `mem_oe_n`=1 throughout. It keeps the memory selected with `mem_we_n`=0 for exactly WR = max(ceil(tWC/clk), ceil(tAW/clk), ceil(tCW/clk), ceil(tWP/clk), ceil(tDW/clk)+1) cycles (default 6). The memory is then deselected for one release cycle.
- R7: The controller drives `mem_dq` only in a write, from the second strobe-low cycle through the release cycle, and never while `mem_oe_n`=0.
- R8: `mem_addr` stays constant for every cycle in which the memory is selected.
- R9: A byte written to an address is returned by a later read of that address.
- R10: `req`, `wr`, `addr` and `wdata` presented while `ready` is low have no effect. No extra access starts and stored contents do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Access request |
| ready | output | 1 | Controller can take a request this cycle |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 13 | Byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid with `rvalid` |
| rvalid | output | 1 | One-cycle read-data strobe |
| mem_addr | output | 13 | Memory address bus |
| mem_ce_n | output | 1 | Memory select, low true |
| mem_ce2 | output | 1 | Memory select, high true |
| mem_we_n | output | 1 | Write strobe, low true |
| mem_oe_n | output | 1 | Output enable, low true |
| mem_dq | inout | 8 | Shared data bus |

## Verification
The bench memory returns undefined data until a read has been selected for the full access count. A controller that samples one cycle early therefore captures X. The bench measures the length of every select window, strobe window and recovery gap, so a wrong rounding in any cycle count shows up as a length mismatch. It also watches who drives the bus on every cycle: drivers switched on in the first strobe cycle, held past the release cycle or left on while the output enable is low all show up as bus-ownership errors. Requests kept high with junk address and data while busy would show as extra select windows or corrupted readback at the lowest and highest addresses.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_RD,
        PH_RD_TA,
        PH_WR,
        PH_WR_REL
    } phase_e;

    typedef struct packed {
        logic ce_n;
        logic ce2;
        logic we_n;
        logic oe_n;
        logic drv;
    } pins_t;

    function automatic int unsigned ns2cyc(input int unsigned ns, input int unsigned clk_ns);
        int unsigned c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/phase_timer.sv
module phase_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] cnt,
    output logic         done
);
    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);

    // R3 / R6: phase lengths depend on an uninterrupted count-down
    a_r3_count_down: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/pin_map.sv
module pin_map
    import sram_seq_pkg::*;
(
    input  phase_e ph,
    input  logic   first_wr,
    output pins_t  pins
);
    always_comb begin
        pins = '{ce_n: 1'b1, ce2: 1'b0, we_n: 1'b1, oe_n: 1'b1, drv: 1'b0};
        unique case (ph)
            PH_RD: begin
                pins.ce_n = 1'b0;
                pins.ce2  = 1'b1;
                pins.oe_n = 1'b0;
            end
            PH_WR: begin
                pins.ce_n = 1'b0;
                pins.ce2  = 1'b1;
                pins.we_n = 1'b0;
                pins.drv  = !first_wr;
            end
            PH_WR_REL: pins.drv = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/dq_port.sv
module dq_port #(
    parameter int DW = 8
) (
    inout  wire  [DW-1:0] dq,
    input  logic          drive,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rd
);
    assign dq = drive ? wdata : {DW{1'bz}};
    assign rd = dq;
endmodule

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
    import sram_seq_pkg::*;
#(
    parameter int unsigned CLK_NS = 10,
    parameter int unsigned T_RC   = 55,
    parameter int unsigned T_AA   = 55,
    parameter int unsigned T_ACE  = 55,
    parameter int unsigned T_OHZ  = 20,
    parameter int unsigned T_WC   = 55,
    parameter int unsigned T_AW   = 50,
    parameter int unsigned T_CW   = 50,
    parameter int unsigned T_WP   = 45,
    parameter int unsigned T_DW   = 25,
    parameter int          AW     = 13,
    parameter int          DW     = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req,
    output logic          ready,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          rvalid,
    output logic [AW-1:0] mem_addr,
    output logic          mem_ce_n,
    output logic          mem_ce2,
    output logic          mem_we_n,
    output logic          mem_oe_n,
    inout  wire  [DW-1:0] mem_dq
);
    localparam int unsigned RD_CYC = umax(umax(ns2cyc(T_RC, CLK_NS), ns2cyc(T_AA, CLK_NS)),
                                          ns2cyc(T_ACE, CLK_NS));
    localparam int unsigned TA_CYC = ns2cyc(T_OHZ, CLK_NS);
    localparam int unsigned WR_CYC = umax(umax(umax(ns2cyc(T_WC, CLK_NS), ns2cyc(T_AW, CLK_NS)),
                                               umax(ns2cyc(T_CW, CLK_NS), ns2cyc(T_WP, CLK_NS))),
                                          ns2cyc(T_DW, CLK_NS) + 1);
    localparam int unsigned MAX_CYC = umax(umax(RD_CYC, TA_CYC), WR_CYC);
    localparam int          CW      = $clog2(MAX_CYC + 1);

    phase_e         ph, ph_nxt;
    logic           t_load, t_done;
    logic [CW-1:0]  t_val, t_cnt;
    logic [AW-1:0]  addr_q;
    logic [DW-1:0]  wdata_q, bus_rd;
    pins_t          pins;

    phase_timer #(.W(CW)) u_timer (
        .clk(clk), .rst(rst), .load(t_load), .load_val(t_val),
        .cnt(t_cnt), .done(t_done)
    );

    pin_map u_pins (
        .ph(ph), .first_wr(t_cnt == CW'(WR_CYC - 1)), .pins(pins)
    );

    dq_port #(.DW(DW)) u_dq (
        .dq(mem_dq), .drive(pins.drv), .wdata(wdata_q), .rd(bus_rd)
    );

    always_comb begin
        ph_nxt = ph;
        t_load = 1'b0;
        t_val  = '0;
        unique case (ph)
            PH_IDLE: if (req) begin
                ph_nxt = wr ? PH_WR : PH_RD;
                t_load = 1'b1;
                t_val  = wr ? CW'(WR_CYC - 1) : CW'(RD_CYC - 1);
            end
            PH_RD: if (t_done) begin
                ph_nxt = PH_RD_TA;
                t_load = 1'b1;
                t_val  = CW'(TA_CYC - 1);
            end
            PH_RD_TA:  if (t_done) ph_nxt = PH_IDLE;
            PH_WR:     if (t_done) ph_nxt = PH_WR_REL;
            PH_WR_REL: ph_nxt = PH_IDLE;
            default:   ph_nxt = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph      <= PH_IDLE;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata   <= '0;
            rvalid  <= 1'b0;
        end else begin
            ph     <= ph_nxt;
            rvalid <= (ph == PH_RD) && t_done;
            if (ph == PH_IDLE && req) begin
                addr_q  <= addr;
                wdata_q <= wdata;
            end
            if (ph == PH_RD && t_done)
                rdata <= bus_rd;
        end
    end

    assign ready    = (ph == PH_IDLE);
    assign mem_addr = addr_q;
    assign mem_ce_n = pins.ce_n;
    assign mem_ce2  = pins.ce2;
    assign mem_we_n = pins.we_n;
    assign mem_oe_n = pins.oe_n;

    // R1: idle means deselected, strobes high, bus released
    a_r1_idle_levels: assert property (@(posedge clk) disable iff (rst)
        ready |-> (mem_ce_n && !mem_ce2 && mem_we_n && mem_oe_n && !pins.drv));

    // R3: both selects always move together
    always_comb a_r3_selects_pair: assert (rst || (mem_ce_n == !mem_ce2));

    // R8: address constant while selected
    a_r8_addr_stable: assert property (@(posedge clk) disable iff (rst)
        (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

    // R6: output enable stays high while the write strobe is low
    a_r6_oe_high_in_write: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> mem_oe_n);

    // R7: drivers never on while the memory may drive
    a_r7_no_drive_with_oe: assert property (@(posedge clk) disable iff (rst)
        pins.drv |-> mem_oe_n);

    // R7: drivers turn on only after a strobe-low cycle
    a_r7_drive_after_we: assert property (@(posedge clk) disable iff (rst)
        $rose(pins.drv) |-> $past(!mem_we_n));

    // R4: valid is a single-cycle pulse
    a_r4_valid_pulse: assert property (@(posedge clk) disable iff (rst)
        rvalid |=> !rvalid);

endmodule

// File: tb/sram_seq_ctrl_tb_top.sv
module sram_seq_ctrl_tb_top;

    localparam int AW = 13;
    localparam int DW = 8;

    function automatic int cyc(input int ns);
        int c;
        c = (ns + 9) / 10;
        return (c < 1) ? 1 : c;
    endfunction

    localparam int RD = 6;   // max(ceil(55/10), ceil(55/10), ceil(55/10))
    localparam int TA = 2;   // ceil(20/10)
    localparam int WR = 6;   // max(6,5,5,5,3+1)

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req = 1'b0;
    logic          wr = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic          ready, rvalid;
    logic [DW-1:0] rdata;
    logic [AW-1:0] mem_addr;
    logic          mem_ce_n, mem_ce2, mem_we_n, mem_oe_n;
    wire  [DW-1:0] mem_dq;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    sram_seq_ctrl dut_i (
        .clk(clk), .rst(rst), .req(req), .ready(ready), .wr(wr),
        .addr(addr), .wdata(wdata), .rdata(rdata), .rvalid(rvalid),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_ce2(mem_ce2),
        .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_dq(mem_dq)
    );

    // behavioural memory, folded to 1024 bytes
    function automatic int fold(input logic [AW-1:0] a);
        return int'(a[9:0] ^ {7'b0, a[12:10]});
    endfunction

    logic [DW-1:0] mem [1024];
    logic [DW-1:0] refm [1024];
    int            sel_cnt = 0;
    logic          m_sel, m_drv;
    logic [DW-1:0] m_out;

    assign m_sel  = !mem_ce_n && mem_ce2;
    assign m_drv  = m_sel && mem_we_n && !mem_oe_n;
    assign m_out  = (sel_cnt >= cyc(55) - 1) ? mem[fold(mem_addr)] : 8'hxx;
    assign mem_dq = m_drv ? m_out : 8'bz;

    always @(posedge clk) sel_cnt <= m_drv ? sel_cnt + 1 : 0;

    always @(negedge clk)
        if (m_sel && !mem_we_n && (^mem_dq !== 1'bx))
            mem[fold(mem_addr)] = mem_dq;

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", rq, act, exp, $time);
        end
    endtask

    // bus and strobe monitor
    int            sel_run = 0, we_run = 0, seen = 0;
    logic [AW-1:0] addr0 = '0;
    bit            bad_addr = 0, bad_drv = 0, bad_oe = 0, bad_idle = 0;

    always @(negedge clk) begin
        logic ctl_drv;
        ctl_drv = !m_drv && (mem_dq !== 8'bz);
        if (!rst) begin
            if (ctl_drv && !mem_oe_n) bad_drv = 1;
            if (m_sel) begin
                if (sel_run == 0) addr0 = mem_addr;
                else if (mem_addr !== addr0) bad_addr = 1;
                sel_run++;
                if (!mem_we_n) begin
                    we_run++;
                    if (!mem_oe_n) bad_oe = 1;
                    if (we_run == 1 && ctl_drv) bad_drv = 1;
                    if (we_run > 1 && !ctl_drv) bad_drv = 1;
                end else if (ctl_drv) bad_drv = 1;
            end else begin
                if (sel_run > 0) begin
                    seen++;
                    if (we_run > 0) begin
                        chk(we_run == WR && sel_run == WR, "R6 write strobe length", we_run, WR);
                        chk(!bad_oe, "R6 oe high during write", bad_oe, 0);
                        if (!ctl_drv) bad_drv = 1;   // release cycle still driven
                    end else begin
                        chk(sel_run == RD, "R3 read select length", sel_run, RD);
                    end
                    chk(!bad_addr, "R8 address stable", bad_addr, 0);
                    chk(!bad_drv, "R7 bus ownership", bad_drv, 0);
                    sel_run = 0; we_run = 0;
                    bad_addr = 0; bad_drv = 0; bad_oe = 0;
                end else if (ctl_drv) begin
                    bad_drv = 1;
                end
                if (ready && mem_dq !== 8'bz) bad_idle = 1;
            end
        end
    end

    task automatic do_op(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d);
        int n = 0, nv = 0, vat = 0;
        logic [DW-1:0] got = '0;
        logic [DW-1:0] exp;
        exp = refm[fold(a)];
        @(negedge clk);
        while (!ready) @(negedge clk);
        req = 1'b1; wr = w; addr = a; wdata = d;
        if (w) refm[fold(a)] = d;
        forever begin
            @(negedge clk);
            n++;
            if (rvalid) begin nv++; vat = n; got = rdata; end
            if (ready) begin req = 1'b0; break; end
            // R10: junk on the user side while busy
            req = 1'($urandom); wr = 1'($urandom);
            addr = AW'($urandom); wdata = DW'($urandom);
        end
        if (w) begin
            chk(n == WR + 2, "R2 write busy length", n, WR + 2);
            chk(nv == 0, "R4 no valid on write", nv, 0);
        end else begin
            chk(n == RD + TA + 1, "R5 read recovery before ready", n, RD + TA + 1);
            chk(nv == 1 && vat == RD + 1, "R4 valid pulse timing", vat, RD + 1);
            chk(got === exp, "R9 read data", got, exp);
        end
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) begin
            mem[i]  = DW'(i * 7 + 3);
            refm[i] = DW'(i * 7 + 3);
        end
        void'($urandom(32'h5EED));
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(mem_ce_n && !mem_ce2 && mem_we_n && mem_oe_n && ready && !rvalid,
            "R1 levels in reset", {mem_ce_n, mem_ce2, mem_we_n, mem_oe_n, ready, rvalid}, 6'b101110);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk(mem_ce_n && !mem_ce2 && mem_we_n && mem_oe_n && ready && !rvalid,
            "R1 levels after reset", {mem_ce_n, mem_ce2, mem_we_n, mem_oe_n, ready, rvalid}, 6'b101110);
        chk(mem_dq === 8'bz, "R1 bus released", int'(mem_dq), 0);
        chk(seen == 0, "R2 no access without request", seen, 0);

        // directed corners
        do_op(1'b0, 13'h0005, 8'h00);   // unwritten location
        do_op(1'b1, 13'h0000, 8'hA5);
        do_op(1'b1, 13'h1FFF, 8'h5A);
        do_op(1'b0, 13'h0000, 8'h00);
        do_op(1'b0, 13'h1FFF, 8'h00);
        do_op(1'b1, 13'h0ABC, 8'hFF);
        do_op(1'b0, 13'h0ABC, 8'h00);   // read straight after write
        do_op(1'b1, 13'h0ABC, 8'h00);
        do_op(1'b1, 13'h0ABC, 8'h3C);   // write after write
        do_op(1'b0, 13'h0ABC, 8'h00);

        for (int k = 0; k < 160; k++)
            do_op(1'($urandom), AW'($urandom), DW'($urandom));

        repeat (4) @(negedge clk);
        chk(seen == 170, "R10 one access per accepted request", seen, 170);
        chk(!bad_idle, "R1 bus released while idle", bad_idle, 0);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog R2 actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule